// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block sits on the configuration side of a programmable device that boots from an external serial memory. When it leaves reset, or when a reconfiguration request arrives, it reads three mode pins. If all three are low, it selects master serial operation. It then holds the memory's reset line for a fixed number of system clocks and drives a configuration clock of its own, made by dividing the system clock. On each rising edge of that clock it captures one bit from the serial data pin.

After a fixed number of bits the loader stops the clock and raises a done output. That output drives the memory's chip enable, so raising it switches the memory off. At the same moment the loader presents the received bits on a parallel bus with a one-cycle valid strobe. A loading indicator stays low for the whole of reset sequencing and bit reception. It is high once loading has finished. Any other mode pattern sends the loader to an error state, in which no clock runs and the memory is left alone.

Top module: `mserial_cfg_loader`

## Requirements
- R1: While `rst_n` is low, every output reads 0 at each system clock edge, including `loading_n_o` and all bits of `bits_o`.
- R2: At the first clock after reset, mode pins equal to 3'b000 start reset sequencing. Any other value enters an error state in which `err_o`=1 and `loading_n_o`=1, while `mem_rst_o`, `done_o` and `cfg_clk_o` stay 0. At most one of `mem_rst_o`, `done_o` and `err_o` is high at any time.
- R3: `mem_rst_o` is high for exactly INIT_CYCLES system clocks before any configuration clock edge. During that time `cfg_clk_o`=0 and `loading_n_o`=0.
- R4: `cfg_clk_o` is 0 outside bit reception. During reception it has a period of CLK_DIV system clocks. Its first rise comes CLK_DIV/2 system clocks after `mem_rst_o` falls.
- R5: `ser_din_i` is captured on the system clock edge at which `cfg_clk_o` rises. The first captured bit ends in `bits_o[BIT_LEN-1]` and the last in `bits_o[0]`.
- R6: Exactly BIT_LEN rising edges of `cfg_clk_o` occur per load. After the last one the clock returns to 0 and stays there.
- R7: `done_o` and `bits_valid_o` rise on the same edge as the final clock rise. `bits_valid_o` is high for one cycle only. `done_o` and `loading_n_o` then stay high with `bits_o` held.
- R8: In the done or error state, a `reconfig_req_i` pulse samples the mode pins again. On 3'b000, `mem_rst_o`=1 and `done_o`=0 from the next cycle and a full load follows. On any other value the loader goes to, or stays in, the error state.
- R9: `reconfig_req_i` has no effect during reset sequencing or bit reception. The load finishes with the same bit count, timing and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; its release acts as power-up |
| mode_pins_i | input | 3 | Mode select pins; 3'b000 selects master serial operation |
| reconfig_req_i | input | 1 | Restart request, honoured in the done and error states |
| ser_din_i | input | 1 | Serial data from the external memory |
| cfg_clk_o | output | 1 | Generated configuration clock |
| mem_rst_o | output | 1 | High while the memory's address counter is held in reset |
| loading_n_o | output | 1 | Low during sequencing and loading, high once finished or in error |
| done_o | output | 1 | Configuration complete; disables the memory's chip enable |
| err_o | output | 1 | Unsupported mode selected |
| bits_o | output | BIT_LEN | Received bits, first received at the MSB |
| bits_valid_o | output | 1 | One-cycle strobe when `bits_o` becomes valid |

## Verification
Loads are run with an irregular pattern, an edges-only pattern (first and last bit set), all ones and all zeros. Together they separate a stuck data path, a reversed bit order and a lost first or last capture. Each load is measured for reset length, time to the first clock rise, clock period and rise count. Loads are started from power-up, from a done-state request and from a recovery out of the error state, which separates the two entry paths. A request injected mid-load and error-state requests carrying a bad mode show whether a request is wrongly honoured.

// File: rtl/mscfg_pkg.sv
`timescale 1ns/100ps
// Shared types for the master serial configuration loader.
package mscfg_pkg;

    // Mode pin pattern that selects master serial operation.
    localparam logic [2:0] MODE_MASTER_SERIAL = 3'b000;

    // Loader sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_LOAD = 3'd2,
        ST_DONE = 3'd3,
        ST_ERR  = 3'd4
    } ld_state_e;

endpackage

// File: rtl/mscfg_clkgen.sv
`timescale 1ns/100ps
// Configuration clock generator.
// Divides the system clock by CLK_DIV while enabled: low for the first half
// of each period, high for the second. rise_stb marks the system clock edge
// at which the output goes high, so data can be captured on that same edge.
// Assumes CLK_DIV is even and at least 2. When disabled the output is low and
// the phase counter restarts at zero.
module mscfg_clkgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic cfg_clk,
    output logic rise_stb
);
    localparam int HALF = CLK_DIV / 2;
    localparam int DCW  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [DCW-1:0] phase_q;
    logic           clk_q;

    // Rising edge of the generated clock happens at the end of the low half.
    assign rise_stb = en && (phase_q == DCW'(HALF - 1));
    assign cfg_clk  = clk_q;

    // Phase counter and generated clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= '0;
            clk_q   <= 1'b0;
        end else begin
            phase_q <= (phase_q == DCW'(CLK_DIV - 1)) ? '0 : phase_q + 1'b1;
            if (rise_stb)
                clk_q <= 1'b1;
            else if (phase_q == DCW'(CLK_DIV - 1))
                clk_q <= 1'b0;
        end
    end

    AST_CLK_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !cfg_clk); // R4
    AST_RISE_FOLLOWS_STB:  assert property (@(posedge clk) disable iff (!rst_n) rise_stb |=> cfg_clk); // R5

endmodule

// File: rtl/mscfg_shift.sv
`timescale 1ns/100ps
// Serial bit receiver.
// Shifts ser_din in on each capture strobe (first bit ends at the MSB) and
// counts captures. last_cap is high on the strobe that delivers bit BIT_LEN.
// Assumes no strobe arrives once BIT_LEN bits are in; clear restarts a load.
module mscfg_shift #(
    parameter int BIT_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               cap_stb,
    input  logic               ser_din,
    output logic [BIT_LEN-1:0] bits,
    output logic               last_cap
);
    localparam int BCW = $clog2(BIT_LEN + 1);

    logic [BIT_LEN-1:0] sr_q;
    logic [BCW-1:0]     cnt_q;

    assign bits     = sr_q;
    assign last_cap = cap_stb && (cnt_q == BCW'(BIT_LEN - 1));

    // Shift register and capture counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (cap_stb) begin
            sr_q  <= {sr_q[BIT_LEN-2:0], ser_din};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= BCW'(BIT_LEN)); // R6

endmodule

// File: rtl/mscfg_fsm.sv
`timescale 1ns/100ps
// Loader sequencer.
// Decodes the mode pins after reset and on each restart request, times the
// memory reset window, waits for the final bit during loading, and raises a
// one-cycle valid strobe on the transition into the done state.
// Assumes last_cap comes from the receiver on the final capture strobe.
module mscfg_fsm #(
    parameter int INIT_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            mode_pins,
    input  logic                  reconfig_req,
    input  logic                  last_cap,
    output mscfg_pkg::ld_state_e  state,
    output logic                  valid_stb
);
    import mscfg_pkg::*;

    localparam int ICW = $clog2(INIT_CYCLES + 1);

    ld_state_e      state_q, state_d;
    logic [ICW-1:0] init_cnt_q;
    logic           valid_q;
    logic           master_sel;

    assign master_sel = (mode_pins == MODE_MASTER_SERIAL);
    assign state      = state_q;
    assign valid_stb  = valid_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: state_d = master_sel ? ST_INIT : ST_ERR;
            ST_INIT: if (init_cnt_q == ICW'(INIT_CYCLES - 1)) state_d = ST_LOAD;
            ST_LOAD: if (last_cap) state_d = ST_DONE;
            ST_DONE,
            ST_ERR:  if (reconfig_req) state_d = master_sel ? ST_INIT : ST_ERR;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and one-cycle completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= (state_q == ST_LOAD) && last_cap;
        end
    end

    // Memory reset window length counter.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_INIT)
            init_cnt_q <= '0;
        else
            init_cnt_q <= init_cnt_q + 1'b1;
    end

    AST_REQ_IGNORED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && reconfig_req && !last_cap) |=> state_q == ST_LOAD); // R9
    AST_REQ_IGNORED_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && init_cnt_q != ICW'(INIT_CYCLES - 1)) |=> state_q == ST_INIT); // R9
    AST_RESTART_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && reconfig_req && master_sel) |=> state_q == ST_INIT); // R8
    AST_BAD_MODE_TO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !master_sel) |=> state_q == ST_ERR); // R2

endmodule

// File: rtl/mserial_cfg_loader.sv
`timescale 1ns/100ps
// Master serial configuration loader (top).
// Sequences the memory reset window, the generated configuration clock, bit
// reception and the completion outputs. Assumes the external memory presents
// its next bit after each rising edge of cfg_clk_o and is reset while
// mem_rst_o is high.
module mserial_cfg_loader #(
    parameter int CLK_DIV     = 4,
    parameter int INIT_CYCLES = 8,
    parameter int BIT_LEN     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_pins_i,
    input  logic               reconfig_req_i,
    input  logic               ser_din_i,
    output logic               cfg_clk_o,
    output logic               mem_rst_o,
    output logic               loading_n_o,
    output logic               done_o,
    output logic               err_o,
    output logic [BIT_LEN-1:0] bits_o,
    output logic               bits_valid_o
);
    import mscfg_pkg::*;

    ld_state_e state;
    logic      clk_en;
    logic      rise_stb;
    logic      last_cap;

    assign clk_en = (state == ST_LOAD);

    mscfg_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_pins    (mode_pins_i),
        .reconfig_req (reconfig_req_i),
        .last_cap     (last_cap),
        .state        (state),
        .valid_stb    (bits_valid_o)
    );

    mscfg_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_en),
        .cfg_clk  (cfg_clk_o),
        .rise_stb (rise_stb)
    );

    mscfg_shift #(.BIT_LEN(BIT_LEN)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_INIT),
        .cap_stb  (rise_stb),
        .ser_din  (ser_din_i),
        .bits     (bits_o),
        .last_cap (last_cap)
    );

    // Output decode from the registered state.
    always_comb begin
        mem_rst_o   = (state == ST_INIT);
        done_o      = (state == ST_DONE);
        err_o       = (state == ST_ERR);
        loading_n_o = (state == ST_DONE) || (state == ST_ERR);
    end

    AST_ONE_PHASE:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_rst_o, done_o, err_o})); // R2
    AST_INIT_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) mem_rst_o |-> !cfg_clk_o); // R3
    AST_VALID_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) bits_valid_o |=> !bits_valid_o); // R7
    AST_VALID_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n) bits_valid_o |-> done_o); // R7
    AST_DONE_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !reconfig_req_i) |=> (done_o && $stable(bits_o) && !cfg_clk_o)); // R6

endmodule

// File: tb/mserial_cfg_loader_bench.sv
`timescale 1ns/100ps
// Directed bench for the master serial configuration loader.
module mserial_cfg_loader_bench;

    localparam int DIV  = 4;
    localparam int INIT = 5;
    localparam int LEN  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     mode_pins_i = 3'b000;
    logic           reconfig_req_i = 1'b0;
    logic           ser_din_i = 1'b0;
    logic           cfg_clk_o, mem_rst_o, loading_n_o, done_o, err_o, bits_valid_o;
    logic [LEN-1:0] bits_o;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    mserial_cfg_loader #(.CLK_DIV(DIV), .INIT_CYCLES(INIT), .BIT_LEN(LEN)) u_mserial_cfg_loader (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_pins_i    (mode_pins_i),
        .reconfig_req_i (reconfig_req_i),
        .ser_din_i      (ser_din_i),
        .cfg_clk_o      (cfg_clk_o),
        .mem_rst_o      (mem_rst_o),
        .loading_n_o    (loading_n_o),
        .done_o         (done_o),
        .err_o          (err_o),
        .bits_o         (bits_o),
        .bits_valid_o   (bits_valid_o)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Entered at a negedge where reset sequencing should be visible; models
    // the memory (next bit after each configuration clock rise) and checks
    // the whole load. req_at >= 0 injects a restart request in that cycle.
    task automatic run_load(input logic [LEN-1:0] pat, input int req_at);
        int n = 0;
        int iter = 0;
        int rises = 0;
        int last_rise = 0;
        logic prev = 1'b0;
        chk("R3 mem_rst high at start", mem_rst_o, 1);
        chk("R8 done low at restart", done_o, 0);
        ser_din_i = pat[LEN-1];
        while (mem_rst_o && n < 1000) begin
            reconfig_req_i = (n == 1 && req_at >= 0);
            chk("R3 no clock in reset window", cfg_clk_o, 0);
            chk("R3 loading_n low in reset window", loading_n_o, 0);
            n++;
            @(negedge clk);
        end
        reconfig_req_i = 1'b0;
        chk("R3 reset window length", n, INIT);
        while (!done_o && iter < LEN * DIV * 4) begin
            reconfig_req_i = (iter == req_at);
            chk("R3 mem_rst low while loading", mem_rst_o, 0);
            chk("R4 loading_n low while loading", loading_n_o, 0);
            if (cfg_clk_o && !prev) begin
                rises++;
                if (rises == 1) chk("R4 first rise delay", iter, DIV / 2);
                else            chk("R4 clock period", iter - last_rise, DIV);
                last_rise = iter;
                if (rises < LEN) ser_din_i = pat[LEN-1-rises];
            end
            prev = cfg_clk_o;
            iter++;
            @(negedge clk);
        end
        reconfig_req_i = 1'b0;
        chk("R7 done with final rise", {31'd0, cfg_clk_o && !prev}, 1);
        rises++;
        chk("R6 rise count", rises, LEN);
        chk("R5 received bits", {16'd0, bits_o}, {16'd0, pat});
        chk("R7 valid strobe", bits_valid_o, 1);
        chk("R7 loading_n high at done", loading_n_o, 1);
        @(negedge clk);
        chk("R7 valid one cycle", bits_valid_o, 0);
        chk("R6 clock stopped", cfg_clk_o, 0);
        chk("R7 done held", done_o, 1);
        for (int i = 0; i < 3 * DIV; i++) begin
            ser_din_i = ~ser_din_i;
            @(negedge clk);
            chk("R6 clock stays low", cfg_clk_o, 0);
            chk("R7 bits held", {16'd0, bits_o}, {16'd0, pat});
        end
    endtask

    task automatic check_err_state(input string tag);
        chk({tag, " R2 err high"}, err_o, 1);
        chk({tag, " R2 loading_n high in error"}, loading_n_o, 1);
        for (int i = 0; i < 3 * DIV; i++) begin
            chk({tag, " R2 no clock in error"}, cfg_clk_o, 0);
            chk({tag, " R2 no mem reset in error"}, mem_rst_o, 0);
            chk({tag, " R2 done low in error"}, done_o, 0);
            @(negedge clk);
        end
    endtask

    // Power-up: hold reset, check reset outputs, release with given mode.
    task automatic t_powerup(input logic [2:0] mode, input logic [LEN-1:0] pat);
        rst_n = 1'b0;
        mode_pins_i = mode;
        repeat (3) @(negedge clk);
        chk("R1 reset cfg_clk", cfg_clk_o, 0);
        chk("R1 reset mem_rst", mem_rst_o, 0);
        chk("R1 reset loading_n", loading_n_o, 0);
        chk("R1 reset done", done_o, 0);
        chk("R1 reset err", err_o, 0);
        chk("R1 reset bits", {16'd0, bits_o}, 0);
        chk("R1 reset valid", bits_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        if (mode == 3'b000) run_load(pat, -1);
        else                check_err_state("powerup");
    endtask

    // Restart request from the done or error state.
    task automatic t_restart(input logic [2:0] mode, input logic [LEN-1:0] pat, input int req_at);
        mode_pins_i = mode;
        reconfig_req_i = 1'b1;
        @(negedge clk);
        reconfig_req_i = 1'b0;
        if (mode == 3'b000) run_load(pat, req_at);
        else                check_err_state("R8 restart bad mode");
    endtask

    initial begin
        t_powerup(3'b000, 16'hA5C3);
        t_restart(3'b000, 16'h8001, -1);
        t_restart(3'b000, 16'h3C96, 5);   // R9 request mid-load
        t_restart(3'b010, '0, -1);
        t_restart(3'b001, '0, -1);        // R8 stays in error
        t_restart(3'b000, 16'hFFFF, -1);  // R8 recovery from error
        t_restart(3'b000, 16'h0000, -1);
        t_powerup(3'b100, '0);            // R2 bad mode at power-up
        t_restart(3'b000, 16'h5A3C, -1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R6 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule